// File: doc/BRIEF.md
# LAPD Transmit Completion Status and Idle-Line Control

This block sits beside a LAPD message transmitter. It watches two pulses from that transmitter, one at the start of a message and one at its end. From them it keeps a busy flag and a sticky completion status. The status clears when the host reads it. The host also gets an interrupt line, which an enable bit gates.

The same block tells the bit serializer what to put on the outbound channel while no message is being sent. It supplies either a repeating flag octet or a steady line of ones. The serializer asks for each idle bit with a tick. The flag pattern starts again from its first bit after every message.

The host sees one 8-bit register through a plain write strobe and a read strobe. Reads are combinational. A read strobe in a cycle clears the status at the end of that cycle.

Top module: `lapd_tx_status`

## Requirements
- R1: A start pulse makes busy (register bit 2) read 1 from the next cycle onward.
- R2: An end pulse without a start pulse makes busy read 0 from the next cycle. An end pulse while busy is 0 is not a completion.
- R3: The interrupt enable (bit 1) is written through the write strobe and reads back. irq_o is high exactly when both status and enable are 1.
- R4: A completion, meaning an end pulse while busy, sets status (bit 0) in the next cycle. Status then holds until it is read. A host write to bit 0 has no effect on it.
- R5: The read data shows the status value from before the clear. A read strobe clears status in the following cycle.
- R6: If a completion and a status read fall in the same cycle, status is 1 after that cycle.
- R7: The idle-flag enable (bit 3) is written through the write strobe. While it is 1 and busy is 0, idle_bit_o carries the octet 0x7E, least significant bit first, and moves on one bit per bit_tick_i.
- R8: While the idle-flag enable is 0, idle_bit_o is 1.
- R9: While busy is 1 the flag bit position is held at bit 0. The first idle bit after a message is therefore bit 0 of the octet.
- R10: After reset, busy, status and enable read 0, the idle-flag enable reads 1, and bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start_i | input | 1 | One-cycle pulse: the transmitter starts a message |
| msg_end_i | input | 1 | One-cycle pulse: the transmitter has finished a message |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe; clears status after this cycle |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Register read data {4'b0, flag_en, busy, irq_en, status} |
| irq_o | output | 1 | Completion interrupt |
| bit_tick_i | input | 1 | Serializer takes one idle bit |
| idle_bit_o | output | 1 | Idle-line bit to send |

## Verification
The completion event and the host read can fall in the same cycle, and they pull status in opposite directions. The vector table provokes this by asserting the end pulse and the read strobe in one row while a message is in flight. The row is judged by the status and irq_o seen in the next cycle, which must both still be 1. A later plain read must then clear status. Start and end arriving together while idle is also driven, and must leave busy set without raising a completion.

// File: rtl/lapd_tx_pkg.sv
package lapd_tx_pkg;
  localparam int REG_W      = 8;
  localparam int STAT_BIT   = 0;
  localparam int IEN_BIT    = 1;
  localparam int BUSY_BIT   = 2;
  localparam int FLAGEN_BIT = 3;

  // Selects one bit of the idle octet, LSB first.
  function automatic logic pick_bit(input logic [7:0] octet, input logic [2:0] idx);
    return octet[idx];
  endfunction

  // Next bit index with wraparound over an octet.
  function automatic logic [2:0] next_idx(input logic [2:0] idx);
    return idx + 3'd1;
  endfunction
endpackage

// File: rtl/lapd_busy_tracker.sv
module lapd_busy_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  output logic busy_o,
  output logic done_o
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (end_i)   busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
  assign done_o = end_i & busy_q;

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o); // R1
  AST_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !start_i) |=> !busy_o); // R2
endmodule

// File: rtl/lapd_irq_status.sv
module lapd_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic ien_wdata_i,
  output logic status_o,
  output logic ien_o,
  output logic irq_o
);
  logic status_q, ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      status_q <= done_i | (status_q & ~rd_i);
      if (wr_i) ien_q <= ien_wdata_i;
    end
  end

  assign status_o = status_q;
  assign ien_o    = ien_q;
  assign irq_o    = status_q & ien_q;

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && !rd_i) |=> status_o); // R4
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done_i) |=> !status_o); // R5
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> status_o); // R6
endmodule

// File: rtl/lapd_idle_flag_gen.sv
module lapd_idle_flag_gen #(
  parameter logic [7:0] IDLE_OCTET = 8'h7E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic tick_i,
  input  logic wr_i,
  input  logic fen_wdata_i,
  output logic flag_en_o,
  output logic idle_bit_o
);
  import lapd_tx_pkg::*;

  logic [2:0] idx_q;
  logic       fen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      fen_q <= 1'b1;
    end else begin
      if (wr_i) fen_q <= fen_wdata_i;
      if (busy_i)      idx_q <= '0;
      else if (tick_i) idx_q <= next_idx(idx_q);
    end
  end

  assign flag_en_o  = fen_q;
  assign idle_bit_o = fen_q ? pick_bit(IDLE_OCTET, idx_q) : 1'b1;

  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (idx_q == 3'd0)); // R9
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && tick_i) |=> (idx_q == $past(idx_q) + 3'd1)); // R7
endmodule

// File: rtl/lapd_tx_status.sv
module lapd_tx_status #(
  parameter logic [7:0] IDLE_OCTET = 8'h7E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msg_start_i,
  input  logic       msg_end_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  input  logic       bit_tick_i,
  output logic       idle_bit_o
);
  import lapd_tx_pkg::*;

  logic busy_w, done_w, status_w, ien_w, fen_w;

  lapd_busy_tracker u_busy (
    .clk(clk), .rst_n(rst_n), .start_i(msg_start_i), .end_i(msg_end_i),
    .busy_o(busy_w), .done_o(done_w)
  );

  lapd_irq_status u_irq (
    .clk(clk), .rst_n(rst_n), .done_i(done_w), .rd_i(reg_rd_i),
    .wr_i(reg_wr_i), .ien_wdata_i(reg_wdata_i[IEN_BIT]),
    .status_o(status_w), .ien_o(ien_w), .irq_o(irq_o)
  );

  lapd_idle_flag_gen #(.IDLE_OCTET(IDLE_OCTET)) u_idle (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_w), .tick_i(bit_tick_i),
    .wr_i(reg_wr_i), .fen_wdata_i(reg_wdata_i[FLAGEN_BIT]),
    .flag_en_o(fen_w), .idle_bit_o(idle_bit_o)
  );

  always_comb begin
    reg_rdata_o             = '0;
    reg_rdata_o[STAT_BIT]   = status_w;
    reg_rdata_o[IEN_BIT]    = ien_w;
    reg_rdata_o[BUSY_BIT]   = busy_w;
    reg_rdata_o[FLAGEN_BIT] = fen_w;
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[IEN_BIT] |-> !irq_o); // R3
  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[FLAGEN_BIT] |-> idle_bit_o); // R8
endmodule

// File: tb/lapd_tx_status_tb.sv
module lapd_tx_status_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_start = 0, msg_end = 0, wr = 0, rd = 0, tick = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, idle_bit;
  int checks = 0, errors = 0;

  always #4 clk = ~clk; // 125 MHz

  lapd_tx_status dut_i (
    .clk(clk), .rst_n(rst_n), .msg_start_i(msg_start), .msg_end_i(msg_end),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .bit_tick_i(tick), .idle_bit_o(idle_bit)
  );

  // {start, end, wr, rd, wdata[3:0], expected rdata[3:0], expected irq}
  localparam int NV = 15;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_0_1_0_1010_1010_0, // R3 enable on
    13'b1_0_0_0_0000_1110_0, // R1 busy set
    13'b0_0_0_0_0000_1110_0, // R1 busy held
    13'b0_1_0_0_0000_1011_1, // R2 R4 complete
    13'b0_0_0_0_0000_1011_1, // R4 held
    13'b0_0_0_1_0000_1010_0, // R5 read clears
    13'b1_0_0_0_0000_1110_0, // R1
    13'b0_1_0_1_0000_1011_1, // R6 collision
    13'b0_0_1_0_1001_1001_0, // R3 enable off gates irq
    13'b0_0_0_1_0000_1000_0, // R5
    13'b0_0_1_0_0011_0010_0, // R4 write to status ignored, R7 fen off
    13'b0_1_0_0_0000_0010_0, // R2 end while idle: no completion
    13'b1_1_0_0_0000_0110_0, // R1 R2 start+end idle
    13'b0_1_0_0_0000_0011_1, // R4 R3 complete with irq
    13'b0_0_0_1_0000_0010_0  // R5
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] flag_oct;
    flag_oct = 8'h7E;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rdata", rdata, 8'h08);
    chk("R10 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rdata after release", rdata, 8'h08);

    for (int i = 0; i < NV; i++) begin
      {msg_start, msg_end, wr, rd} = VEC[i][12:9];
      wdata = {4'b0, VEC[i][8:5]};
      step();
      {msg_start, msg_end, wr, rd} = '0;
      wdata = '0;
      chk($sformatf("R1-row%0d rdata", i), rdata, {4'b0, VEC[i][4:1]});
      chk($sformatf("R3-row%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R8: flags disabled (state now fen=0, idle) -> all ones
    for (int b = 0; b < 8; b++) begin
      chk("R8 idle ones", {7'd0, idle_bit}, 8'h01);
      tick = 1; step(); tick = 0;
    end

    // R7: enable flags, check two octets LSB first
    wr = 1; wdata = 8'h08; step(); wr = 0; wdata = '0;
    msg_start = 1; step(); msg_start = 0;      // R9 restart index
    msg_end = 1; step(); msg_end = 0;
    for (int b = 0; b < 16; b++) begin
      chk("R7 flag bit", {7'd0, idle_bit}, {7'd0, flag_oct[b % 8]});
      tick = 1; step(); tick = 0;
    end

    // R9: stop mid-octet, run a message, first idle bit is bit 0
    repeat (3) begin tick = 1; step(); tick = 0; end
    chk("R9 mid-octet bit3", {7'd0, idle_bit}, {7'd0, flag_oct[3]});
    msg_start = 1; step(); msg_start = 0;
    tick = 1; step(); tick = 0;   // tick while busy: index held
    msg_end = 1; step(); msg_end = 0;
    chk("R9 restart bit0", {7'd0, idle_bit}, {7'd0, flag_oct[0]});
    tick = 1; step(); tick = 0;
    chk("R9 then bit1", {7'd0, idle_bit}, {7'd0, flag_oct[1]});
    // R6 corner: status from that message, read and event clear cleanly
    chk("R4 status set", {7'd0, rdata[0]}, 8'h01);
    rd = 1; step(); rd = 0;
    chk("R5 cleared", {7'd0, rdata[0]}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule